// File: doc/BRIEF.md
# Access violation shift-sync capture unit

This unit sits beside a bus permission checker and keeps the details of rejected accesses. Violation sources are arranged in groups. Each group latches the first violation it sees: the master ID, the domain ID, whether the access was a read or a write, and a 36-bit address. The group then holds a pending flag until software clears it. The details cannot be read directly. Software has to bring one group's record across to two debug words through a timed handshake.

The handshake runs as follows. Software reads the group status word and picks the lowest set bit. It writes that group as a one-hot value to the select word, then writes 1 to the control word. After a fixed serial transfer time the control word reads 0x3 and the debug words hold the record. Software then writes 0 to the control word and writes 1 to the group's status bit to clear it. Register access is a single-cycle 32-bit write strobe with a combinational read path, addressed by byte offset: 0x900 and 0x904 for the debug words, 0xF10 for status, 0xF14 for select and 0xF20 for control.

Top module: `vio_capture`

## Requirements
- R1: After reset, the status, select, control and both debug words read 0.
- R2: A pulse on `vio_valid_i[g]` sets bit g of the status word (0xF10) from the next cycle. Each group has its own bit.
- R3: While group g is pending, further violations on g are dropped. The record of the first violation is kept until the group is cleared, and the next violation after the clear is recorded.
- R4: Writing the status word clears every group whose data bit is 1 and leaves groups written with 0 unchanged. A shift never clears status.
- R5: The select word (0xF14) stores the low NUM_GROUPS bits of the written data. Higher bits read as 0.
- R6: Writing data with bit 0 = 1 to the control word (0xF20) starts a shift. The control word then reads 0x1 (bit 0 = started, bit 1 = done) and reads 0x3 from exactly SHIFT_CYCLES clock edges after the write edge. Bit 1 is never set before that.
- R7: At completion, if select is one-hot and names a pending group, debug word 0 (0x900) reads {4'b0, addr[35:32], rd, wr, domain[5:0], master[15:0]} (bit 22 = write flag, bit 23 = read flag) and debug word 1 (0x904) reads addr[31:0].
- R8: At completion, if select is zero, has more than one bit set, or names a group with nothing pending, both debug words become 0.
- R9: Writing 0 to the control word during a shift aborts it. Control reads 0, bit 1 never appears for that shift, and the debug words keep their previous values.
- R10: Writing 0 to the control word after completion makes it read 0. The debug words keep the transferred record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational from addr_i) |
| vio_valid_i | input | NUM_GROUPS | Per-group violation pulse |
| vio_mst_i | input | NUM_GROUPS*16 | Per-group master ID |
| vio_dom_i | input | NUM_GROUPS*6 | Per-group domain ID |
| vio_wr_i | input | NUM_GROUPS | Per-group write-violation flag |
| vio_rd_i | input | NUM_GROUPS | Per-group read-violation flag |
| vio_addr_i | input | NUM_GROUPS*36 | Per-group violating address |

## Verification
The bench builds the unit with NUM_GROUPS = 4 and SHIFT_CYCLES = 8. With these values every one of the 16 possible select codes can be swept against a known pending pattern, which covers all one-hot, multi-hot, zero and non-pending selections. All 16 clear masks can also be applied to a fully pending status word. Eight shift cycles make the countdown long enough to check the control word at every edge and to abort part-way through a transfer.

// File: rtl/vio_pkg.sv
package vio_pkg;
  localparam int MST_W   = 16;
  localparam int DOM_W   = 6;
  localparam int VADDR_W = 36;

  localparam logic [11:0] OFS_DBG0 = 12'h900;
  localparam logic [11:0] OFS_DBG1 = 12'h904;
  localparam logic [11:0] OFS_STA  = 12'hF10;
  localparam logic [11:0] OFS_SEL  = 12'hF14;
  localparam logic [11:0] OFS_CTL  = 12'hF20;

  typedef struct packed {
    logic [VADDR_W-1:0] addr;
    logic               rd;
    logic               wr;
    logic [DOM_W-1:0]   dom;
    logic [MST_W-1:0]   mst;
  } vio_rec_t;
endpackage

// File: rtl/vio_group_store.sv
module vio_group_store
  import vio_pkg::*;
#(
  parameter int NUM_GROUPS = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_GROUPS-1:0]            hit_i,
  input  vio_rec_t [NUM_GROUPS-1:0]        rec_i,
  input  logic [NUM_GROUPS-1:0]            clr_i,
  output logic [NUM_GROUPS-1:0]            pend_o,
  output vio_rec_t [NUM_GROUPS-1:0]        rec_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_o[g] <= 1'b0;
        rec_o[g]  <= '0;
      end else if (clr_i[g]) begin
        pend_o[g] <= 1'b0;
      end else if (hit_i[g] && !pend_o[g]) begin
        // first violation wins; later ones dropped until clear
        pend_o[g] <= 1'b1;
        rec_o[g]  <= rec_i[g];
      end
    end
  end
endmodule

// File: rtl/vio_shift_ctrl.sv
module vio_shift_ctrl #(
  parameter int SHIFT_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctl_we_i,
  input  logic ctl_go_i,
  output logic busy_o,
  output logic go_o,
  output logic done_o,
  output logic load_o
);
  localparam int CNT_W = $clog2(SHIFT_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic abort, launch;

  assign abort  = ctl_we_i && !ctl_go_i;
  assign launch = ctl_we_i && ctl_go_i && !busy_o;
  assign load_o = busy_o && !abort && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      go_o   <= 1'b0;
      done_o <= 1'b0;
      cnt_q  <= '0;
    end else if (abort) begin
      busy_o <= 1'b0;
      go_o   <= 1'b0;
      done_o <= 1'b0;
    end else if (launch) begin
      busy_o <= 1'b1;
      go_o   <= 1'b1;
      done_o <= 1'b0;
      cnt_q  <= CNT_W'(SHIFT_CYCLES);
    end else if (busy_o) begin
      if (cnt_q == CNT_W'(1)) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/vio_capture.sv
module vio_capture
  import vio_pkg::*;
#(
  parameter int NUM_GROUPS   = 4,
  parameter int SHIFT_CYCLES = 8,
  parameter int ADDR_W       = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [31:0]                   wdata_i,
  output logic [31:0]                   rdata_o,
  input  logic [NUM_GROUPS-1:0]         vio_valid_i,
  input  logic [NUM_GROUPS*MST_W-1:0]   vio_mst_i,
  input  logic [NUM_GROUPS*DOM_W-1:0]   vio_dom_i,
  input  logic [NUM_GROUPS-1:0]         vio_wr_i,
  input  logic [NUM_GROUPS-1:0]         vio_rd_i,
  input  logic [NUM_GROUPS*VADDR_W-1:0] vio_addr_i
);
  localparam int GW = NUM_GROUPS;

  vio_rec_t [GW-1:0] rec_in, rec_q;
  logic [GW-1:0] pend, clr, sel_q;
  logic [31:0]   dbg0_q, dbg1_q;
  logic          wr_sta, wr_sel, wr_ctl;
  logic          busy, go, done, load;
  logic          sel_ok;
  vio_rec_t      pick;
  logic          unused_wdata;

  for (genvar g = 0; g < GW; g++) begin : g_rec
    assign rec_in[g].mst  = vio_mst_i[g*MST_W +: MST_W];
    assign rec_in[g].dom  = vio_dom_i[g*DOM_W +: DOM_W];
    assign rec_in[g].wr   = vio_wr_i[g];
    assign rec_in[g].rd   = vio_rd_i[g];
    assign rec_in[g].addr = vio_addr_i[g*VADDR_W +: VADDR_W];
  end

  assign wr_sta = wr_en_i && (addr_i == ADDR_W'(OFS_STA));
  assign wr_sel = wr_en_i && (addr_i == ADDR_W'(OFS_SEL));
  assign wr_ctl = wr_en_i && (addr_i == ADDR_W'(OFS_CTL));
  assign clr    = wr_sta ? wdata_i[GW-1:0] : '0;
  assign unused_wdata = ^wdata_i;

  vio_group_store #(.NUM_GROUPS(GW)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (vio_valid_i),
    .rec_i  (rec_in),
    .clr_i  (clr),
    .pend_o (pend),
    .rec_o  (rec_q)
  );

  vio_shift_ctrl #(.SHIFT_CYCLES(SHIFT_CYCLES)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_we_i (wr_ctl),
    .ctl_go_i (wdata_i[0]),
    .busy_o   (busy),
    .go_o     (go),
    .done_o   (done),
    .load_o   (load)
  );

  // selection must be one-hot and pending, otherwise zeros are shifted
  assign sel_ok = (sel_q != '0) && ((sel_q & (sel_q - GW'(1))) == '0);

  always_comb begin
    pick = '0;
    for (int g = 0; g < GW; g++) begin
      if (sel_ok && sel_q[g] && pend[g]) pick = rec_q[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      dbg0_q <= '0;
      dbg1_q <= '0;
    end else begin
      if (wr_sel) sel_q <= wdata_i[GW-1:0];
      if (load) begin
        dbg0_q <= {4'b0, pick.addr[VADDR_W-1:32], pick.rd, pick.wr, pick.dom, pick.mst};
        dbg1_q <= pick.addr[31:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_DBG0))     rdata_o = dbg0_q;
    else if (addr_i == ADDR_W'(OFS_DBG1)) rdata_o = dbg1_q;
    else if (addr_i == ADDR_W'(OFS_STA))  rdata_o = 32'(pend);
    else if (addr_i == ADDR_W'(OFS_SEL))  rdata_o = 32'(sel_q);
    else if (addr_i == ADDR_W'(OFS_CTL))  rdata_o = {30'b0, done, go};
  end
endmodule

// File: rtl/vio_capture_chk.sv
module vio_capture_chk #(
  parameter int NUM_GROUPS = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_GROUPS-1:0] clr_i,
  input logic [NUM_GROUPS-1:0] pend_i,
  input logic                  busy_i,
  input logic                  go_i,
  input logic                  done_i,
  input logic                  ctrl_wr_i,
  input logic                  wdata0_i,
  input logic [31:0]           dbg0_i,
  input logic [31:0]           dbg1_i
);
  // R4
  pend_drop_only_by_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(pend_i) & ~pend_i) & ~$past(clr_i)) == '0));

  // R6
  done_after_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $past(busy_i));

  // R6
  done_implies_started_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> go_i);

  // R9
  abort_clears_ctl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && !wdata0_i) |=> (!busy_i && !done_i && !go_i));

  // R7
  dbg_moves_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(dbg0_i) || !$stable(dbg1_i)) |-> $rose(done_i));
endmodule

bind vio_capture vio_capture_chk #(.NUM_GROUPS(NUM_GROUPS)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr),
  .pend_i    (pend),
  .busy_i    (busy),
  .go_i      (go),
  .done_i    (done),
  .ctrl_wr_i (wr_ctl),
  .wdata0_i  (wdata_i[0]),
  .dbg0_i    (dbg0_q),
  .dbg1_i    (dbg1_q)
);

// File: tb/vio_capture_tb_top.sv
module vio_capture_tb_top;
  localparam int NG = 4;
  localparam int SC = 8;
  localparam logic [11:0] A_DBG0 = 12'h900;
  localparam logic [11:0] A_DBG1 = 12'h904;
  localparam logic [11:0] A_STA  = 12'hF10;
  localparam logic [11:0] A_SEL  = 12'hF14;
  localparam logic [11:0] A_CTL  = 12'hF20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NG-1:0] valid = '0;
  logic [NG*16-1:0] mst = '0;
  logic [NG*6-1:0] dom = '0;
  logic [NG-1:0] vw = '0, vr = '0;
  logic [NG*36-1:0] vaddr = '0;

  int n_run = 0, n_fail = 0;

  logic        m_pend [NG];
  logic [15:0] m_mst  [NG];
  logic [5:0]  m_dom  [NG];
  logic        m_w    [NG];
  logic        m_r    [NG];
  logic [35:0] m_addr [NG];

  always #2 clk = ~clk;

  vio_capture #(.NUM_GROUPS(NG), .SHIFT_CYCLES(SC), .ADDR_W(12)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .vio_valid_i(valid),
    .vio_mst_i(mst), .vio_dom_i(dom), .vio_wr_i(vw), .vio_rd_i(vr),
    .vio_addr_i(vaddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic inject(input logic [NG-1:0] mask, input int s);
    @(negedge clk);
    for (int g = 0; g < NG; g++) begin
      if (mask[g]) begin
        logic [15:0] fm;
        logic [5:0]  fd;
        logic        fw;
        logic [35:0] fa;
        fm = 16'hA000 + 16'(s * 16 + g);
        fd = 6'((s * 4 + g) & 63);
        fw = 1'((s + g) % 2);
        fa = {4'(g + s + 1), 32'hDEAD_0000 + 32'(s * 256 + g)};
        valid[g] = 1'b1;
        mst[g*16 +: 16] = fm;
        dom[g*6 +: 6] = fd;
        vw[g] = fw;
        vr[g] = ~fw;
        vaddr[g*36 +: 36] = fa;
        if (!m_pend[g]) begin
          m_pend[g] = 1'b1; m_mst[g] = fm; m_dom[g] = fd;
          m_w[g] = fw; m_r[g] = ~fw; m_addr[g] = fa;
        end
      end
    end
    @(negedge clk);
    valid = '0;
  endtask

  function automatic logic [31:0] m_sta();
    logic [31:0] v = '0;
    for (int g = 0; g < NG; g++) v[g] = m_pend[g];
    return v;
  endfunction

  function automatic int m_target(input logic [NG-1:0] s);
    if (s == '0 || (s & (s - 1'b1)) != '0) return -1;
    for (int g = 0; g < NG; g++) if (s[g] && m_pend[g]) return g;
    return -1;
  endfunction

  task automatic w1c(input logic [NG-1:0] mask);
    wr(A_STA, 32'(mask));
    for (int g = 0; g < NG; g++) if (mask[g]) m_pend[g] = 1'b0;
  endtask

  // start shift and check control word at every edge (R6)
  task automatic run_shift();
    wr(A_CTL, 32'h1);
    #1 chk("R6 started", rdata, 32'h1);
    for (int k = 1; k <= SC; k++) begin
      @(negedge clk);
      #1 chk("R6 timing", rdata, (k == SC) ? 32'h3 : 32'h1);
    end
  endtask

  task automatic sync_check(input logic [NG-1:0] s, output logic [31:0] e0, output logic [31:0] e1);
    logic [31:0] d;
    int t;
    wr(A_SEL, 32'(s));
    rd(A_SEL, d); chk("R5 select", d, 32'(s));
    t = m_target(s);
    if (t >= 0) begin
      e0 = {4'b0, m_addr[t][35:32], m_r[t], m_w[t], m_dom[t], m_mst[t]};
      e1 = m_addr[t][31:0];
    end else begin
      e0 = '0; e1 = '0;
    end
    addr = A_CTL;
    run_shift();
    rd(A_DBG0, d); chk(t >= 0 ? "R7 dbg0" : "R8 dbg0", d, e0);
    rd(A_DBG1, d); chk(t >= 0 ? "R7 dbg1" : "R8 dbg1", d, e1);
    wr(A_CTL, 32'h0);
    rd(A_CTL, d); chk("R10 ctl", d, 32'h0);
    rd(A_DBG0, d); chk("R10 dbg0", d, e0);
    rd(A_DBG1, d); chk("R10 dbg1", d, e1);
    rd(A_STA, d); chk("R4 no clear by shift", d, m_sta());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, e0, e1, k0, k1;
    for (int g = 0; g < NG; g++) begin
      m_pend[g] = 1'b0; m_mst[g] = '0; m_dom[g] = '0;
      m_w[g] = 1'b0; m_r[g] = 1'b0; m_addr[g] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1
    rd(A_STA, d);  chk("R1 sta", d, 0);
    rd(A_SEL, d);  chk("R1 sel", d, 0);
    rd(A_CTL, d);  chk("R1 ctl", d, 0);
    rd(A_DBG0, d); chk("R1 dbg0", d, 0);
    rd(A_DBG1, d); chk("R1 dbg1", d, 0);

    // R2
    inject(4'b0101, 0);
    rd(A_STA, d); chk("R2 sta", d, 32'h5);
    // R3: second violation on group 0 dropped
    inject(4'b0001, 1);
    rd(A_STA, d); chk("R3 sta", d, 32'h5);

    // R5 upper bits
    wr(A_SEL, 32'hFFFF_FFF1);
    rd(A_SEL, d); chk("R5 upper bits", d, 32'h1);

    // full select sweep: R3 R6 R7 R8 R10
    for (int s = 0; s < 16; s++) sync_check(4'(s), e0, e1);

    // R9 abort
    sync_check(4'b0001, k0, k1);
    wr(A_SEL, 32'h4);
    wr(A_CTL, 32'h1);
    repeat (3) @(negedge clk);
    wr(A_CTL, 32'h0);
    rd(A_CTL, d); chk("R9 ctl", d, 0);
    repeat (SC + 4) @(negedge clk);
    rd(A_CTL, d); chk("R9 no done", d, 0);
    rd(A_DBG0, d); chk("R9 dbg0 kept", d, k0);
    rd(A_DBG1, d); chk("R9 dbg1 kept", d, k1);

    // R4 and R3 after clear
    w1c(4'b0001);
    rd(A_STA, d); chk("R4 w1c", d, 32'h4);
    inject(4'b0001, 2);
    rd(A_STA, d); chk("R3 re-arm", d, 32'h5);
    sync_check(4'b0001, e0, e1);

    // R4 exhaustive clear masks
    for (int mk = 0; mk < 16; mk++) begin
      w1c(4'hF);
      inject(4'hF, mk + 3);
      rd(A_STA, d); chk("R2 all pending", d, 32'hF);
      w1c(4'(mk));
      rd(A_STA, d); chk("R4 mask", d, m_sta());
    end
    sync_check(4'b1000, e0, e1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule